// File: doc/BRIEF.md
# Micro-step Position Translator

This block holds the electrical angle of a two-phase bipolar stepper motor as a 7-bit index on a circle of 128 points, one point per 1/32 of a full step. Each step trigger moves the index by the stride of the active step mode, in the active direction. From the index it produces signed set points for the currents in coil X and coil Y. The current loop uses these set points, and software can read the index back.

A step trigger comes from the rising edge of a synchronized step pin, or from a software step request that clears itself. The active step mode is the sum of a 3-bit register mode and a 2-bit pin mode. The active direction is the direction pin XOR a polarity bit. A change of mode or direction has no effect until the next trigger. When a trigger lands on an index that is off the new mode's grid, the index moves to the nearest grid point in the direction of travel. That same rule produces the 45-degree shift when the block changes between the two full-step variants.

Top module: `stepper_positioner`

## Requirements
- R1: While reset is asserted, and after it is released, the index is 16 and both coil outputs are +707 until the first trigger.
- R2: The step pin passes through a two-flop synchronizer. Only a rising edge makes a trigger. A pin held high, or a falling edge, leaves the index unchanged.
- R3: A one-cycle pulse on `sw_step_set` sets `sw_step_pending` one cycle later. The pending bit causes a single step and then clears. A pin edge and a pending bit seen in the same cycle produce one step, not two.
- R4: The active mode is (`reg_mode` + `step_pins`) modulo 8. Codes 0 to 4 give strides of 1, 2, 4, 8 and 16 index units. Codes 5 and 6 give one-coil full step. Code 7 gives two-coil full step. Both full-step variants have a stride of 32.
- R5: The active direction is `dir_pin` XOR `dir_polarity`. A value of 1 increases the index and 0 decreases it. The index wraps modulo 128.
- R6: A change of mode, pins or direction with no trigger never moves the index.
- R7: If the index is off the active grid when a trigger arrives, it moves to the next grid point above when travelling forward, or to the next grid point below when travelling backward. The grid point is never skipped.
- R8: One-coil full step lands on multiples of 32. Two-coil full step lands on 16 plus multiples of 32. A change between the two variants moves the index by 16 units on the next trigger.
- R9: `coil_x` is the cosine and `coil_y` is the sine of the index angle, in signed tenths of a percent, taken from a 33-point quarter sine. Index 0 gives (1000,0), index 32 gives (0,1000), index 64 gives (-1000,0), index 48 gives (-707,707) and index 24 gives (383,924).
- R10: `position` shows the registered index. It is updated on the clock edge that consumes the trigger, and the coil outputs change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nxt_pin | input | 1 | Step pin, asynchronous, rising edge steps |
| dir_pin | input | 1 | Direction pin |
| step_pins | input | 2 | Pin step-mode offset |
| reg_mode | input | 3 | Register step mode |
| dir_polarity | input | 1 | Direction inversion bit |
| sw_step_set | input | 1 | Software step request pulse |
| sw_step_pending | output | 1 | Software step bit, clears itself |
| position | output | 7 | Electrical index in 1/32-step units |
| coil_x | output | 11 | Coil X set point, signed tenths of a percent |
| coil_y | output | 11 | Coil Y set point, signed tenths of a percent |

## Verification
A synchronized pin edge and a pending software step can fall in the same cycle. The bench raises the pin one cycle before it pulses the software request, so that the edge leaves the synchronizer in the same cycle the pending bit is set. It then requires exactly one step of the index, a cleared pending bit, and no further movement over the following cycles. Grid snapping and wraparound are judged at the ports against index values worked out by hand for each mode change.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int FRAC_BITS = 5;
  localparam int POS_W     = FRAC_BITS + 2;
  localparam int AMP_W     = 11;
  localparam logic [POS_W-1:0] POS_RESET = POS_W'(1 << (FRAC_BITS - 1));

  typedef logic [POS_W-1:0] pos_t;
  typedef logic signed [AMP_W-1:0] amp_t;

  typedef enum logic [2:0] {
    MODE_M32  = 3'd0,
    MODE_M16  = 3'd1,
    MODE_M8   = 3'd2,
    MODE_M4   = 3'd3,
    MODE_M2   = 3'd4,
    MODE_FS1A = 3'd5,
    MODE_FS1B = 3'd6,
    MODE_FS2  = 3'd7
  } step_mode_t;

  // quarter sine, tenths of a percent, k in 0..32
  function automatic logic [AMP_W-2:0] qsine(input logic [FRAC_BITS:0] k);
    logic [AMP_W-2:0] v;
    case (k)
      6'd0:  v = 10'd0;    6'd1:  v = 10'd49;   6'd2:  v = 10'd98;
      6'd3:  v = 10'd147;  6'd4:  v = 10'd195;  6'd5:  v = 10'd243;
      6'd6:  v = 10'd290;  6'd7:  v = 10'd337;  6'd8:  v = 10'd383;
      6'd9:  v = 10'd428;  6'd10: v = 10'd471;  6'd11: v = 10'd514;
      6'd12: v = 10'd556;  6'd13: v = 10'd596;  6'd14: v = 10'd634;
      6'd15: v = 10'd672;  6'd16: v = 10'd707;  6'd17: v = 10'd741;
      6'd18: v = 10'd773;  6'd19: v = 10'd803;  6'd20: v = 10'd831;
      6'd21: v = 10'd858;  6'd22: v = 10'd882;  6'd23: v = 10'd904;
      6'd24: v = 10'd924;  6'd25: v = 10'd942;  6'd26: v = 10'd957;
      6'd27: v = 10'd970;  6'd28: v = 10'd981;  6'd29: v = 10'd989;
      6'd30: v = 10'd995;  6'd31: v = 10'd999;
      default: v = 10'd1000;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/stp_trigger.sv
module stp_trigger #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nxt_pin,
  input  logic sw_step_set,
  output logic fire,
  output logic sw_pending
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   pend_q;
  logic                   pend_d;
  logic                   pin_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= nxt_pin;
  end

  genvar g;
  generate
    for (g = 1; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign pin_rise = sync_q[SYNC_STAGES-1] & ~last_q;
  assign fire     = pin_rise | pend_q;

  // a new request outranks the clear of an older one
  always_comb begin
    pend_d = pend_q;
    if (fire)        pend_d = 1'b0;
    if (sw_step_set) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      last_q <= sync_q[SYNC_STAGES-1];
      pend_q <= pend_d;
    end
  end

  assign sw_pending = pend_q;
endmodule

// File: rtl/stp_next_pos.sv
module stp_next_pos
  import stp_pkg::*;
(
  input  pos_t       cur_pos,
  input  logic [2:0] reg_mode,
  input  logic [1:0] step_pins,
  input  logic       forward,
  output pos_t       new_pos
);
  step_mode_t eff_mode;
  pos_t       stride;
  pos_t       mask;
  pos_t       offset;
  pos_t       rel;
  pos_t       rel_next;
  logic       on_grid;

  assign eff_mode = step_mode_t'(reg_mode + {1'b0, step_pins});

  always_comb begin
    case (eff_mode)
      MODE_M32, MODE_M16, MODE_M8, MODE_M4, MODE_M2:
        stride = pos_t'(1) << eff_mode;
      default:
        stride = pos_t'(1 << FRAC_BITS);
    endcase
    offset  = (eff_mode == MODE_FS2) ? POS_RESET : '0;
    mask    = stride - pos_t'(1);
    rel     = cur_pos - offset;
    on_grid = ((rel & mask) == '0);
    if (forward) rel_next = on_grid ? (rel + stride) : ((rel | mask) + pos_t'(1));
    else         rel_next = on_grid ? (rel - stride) : (rel & ~mask);
    new_pos = rel_next + offset;
  end
endmodule

// File: rtl/stp_coil_fold.sv
module stp_coil_fold
  import stp_pkg::*;
#(
  parameter int PHASE = 0
) (
  input  pos_t pos,
  output amp_t amp
);
  pos_t                 ang;
  logic [1:0]           quad;
  logic [FRAC_BITS-1:0] frac;
  logic [FRAC_BITS:0]   idx;
  logic [AMP_W-2:0]     mag;

  always_comb begin
    ang  = pos + pos_t'(PHASE);
    quad = ang[POS_W-1 -: 2];
    frac = ang[FRAC_BITS-1:0];
    idx  = quad[0] ? ((FRAC_BITS+1)'(1 << FRAC_BITS) - {1'b0, frac}) : {1'b0, frac};
    mag  = qsine(idx);
    amp  = quad[1] ? -amp_t'({1'b0, mag}) : amp_t'({1'b0, mag});
  end
endmodule

// File: rtl/stepper_positioner.sv
module stepper_positioner
  import stp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nxt_pin,
  input  logic        dir_pin,
  input  logic [1:0]  step_pins,
  input  logic [2:0]  reg_mode,
  input  logic        dir_polarity,
  input  logic        sw_step_set,
  output logic        sw_step_pending,
  output logic [6:0]  position,
  output logic signed [10:0] coil_x,
  output logic signed [10:0] coil_y
);
  localparam int AXES = 2;

  logic [1:0] rst_sync_q;
  logic       rst_q_n;
  logic       step_fire;
  pos_t       pos_q;
  pos_t       pos_d;
  pos_t       pos_cand;
  amp_t       axis_amp [AXES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  stp_trigger #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .nxt_pin     (nxt_pin),
    .sw_step_set (sw_step_set),
    .fire        (step_fire),
    .sw_pending  (sw_step_pending)
  );

  stp_next_pos u_next (
    .cur_pos   (pos_q),
    .reg_mode  (reg_mode),
    .step_pins (step_pins),
    .forward   (dir_pin ^ dir_polarity),
    .new_pos   (pos_cand)
  );

  always_comb begin
    pos_d = pos_q;
    if (step_fire) pos_d = pos_cand;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pos_q <= POS_RESET;
    else          pos_q <= pos_d;
  end

  // axis 0 = Y (sine), axis 1 = X (cosine, quarter-turn ahead)
  genvar a;
  generate
    for (a = 0; a < AXES; a++) begin : g_axis
      stp_coil_fold #(.PHASE(a << FRAC_BITS)) u_fold (
        .pos (pos_q),
        .amp (axis_amp[a])
      );
    end
  endgenerate

  assign position = pos_q;
  assign coil_y   = axis_amp[0];
  assign coil_x   = axis_amp[1];
endmodule

// File: rtl/stepper_positioner_chk.sv
module stepper_positioner_chk (
  input logic        clk,
  input logic        rst_q_n,
  input logic        fire,
  input logic        sw_set,
  input logic        sw_pending,
  input logic [2:0]  reg_mode,
  input logic [1:0]  step_pins,
  input logic [6:0]  position,
  input logic signed [10:0] coil_x,
  input logic signed [10:0] coil_y
);
  logic [2:0] mode_sum;
  int         power;

  assign mode_sum = reg_mode + {1'b0, step_pins};
  assign power    = int'(coil_x) * int'(coil_x) + int'(coil_y) * int'(coil_y);

  a_r6_hold_without_trigger: assert property (@(posedge clk) disable iff (!rst_q_n)
    !fire |=> $stable(position));

  a_r2_trigger_moves: assert property (@(posedge clk) disable iff (!rst_q_n)
    fire |=> (position != $past(position)));

  a_r3_sw_self_clear: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sw_pending && !sw_set) |=> !sw_pending);

  a_r8_one_coil_grid: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fire && (mode_sum == 3'd5 || mode_sum == 3'd6)) |=> (position[4:0] == 5'd0));

  a_r8_two_coil_grid: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fire && mode_sum == 3'd7) |=> (position[4:0] == 5'd16));

  a_r9_vector_length: assert property (@(posedge clk) disable iff (!rst_q_n)
    (power >= 990000 && power <= 1010000));
endmodule

bind stepper_positioner stepper_positioner_chk u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .fire       (step_fire),
  .sw_set     (sw_step_set),
  .sw_pending (sw_step_pending),
  .reg_mode   (reg_mode),
  .step_pins  (step_pins),
  .position   (position),
  .coil_x     (coil_x),
  .coil_y     (coil_y)
);

// File: tb/tb_stepper_positioner.sv
module tb_stepper_positioner;
  logic clk;
  logic rst_n;
  logic nxt_pin;
  logic dir_pin;
  logic [1:0] step_pins;
  logic [2:0] reg_mode;
  logic dir_polarity;
  logic sw_step_set;
  logic sw_step_pending;
  logic [6:0] position;
  logic signed [10:0] coil_x;
  logic signed [10:0] coil_y;

  int checks;
  int failures;
  bit done;

  stepper_positioner dut (
    .clk(clk), .rst_n(rst_n), .nxt_pin(nxt_pin), .dir_pin(dir_pin),
    .step_pins(step_pins), .reg_mode(reg_mode), .dir_polarity(dir_polarity),
    .sw_step_set(sw_step_set), .sw_step_pending(sw_step_pending),
    .position(position), .coil_x(coil_x), .coil_y(coil_y)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_pos(input string req, input int p, input int x, input int y);
    check({req, " position"}, int'(position), p);
    check({req, " coil_x"}, int'(coil_x), x);
    check({req, " coil_y"}, int'(coil_y), y);
  endtask

  task automatic pulse_nxt();
    @(negedge clk) nxt_pin = 1'b1;
    repeat (5) @(negedge clk);
    nxt_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic [1:0] p, input logic d, input logic pol);
    @(negedge clk);
    reg_mode = m; step_pins = p; dir_pin = d; dir_polarity = pol;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_pos("R1 in reset", 16, 707, 707);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_pos("R1 after release", 16, 707, 707);
  endtask

  task automatic t_pin_edge();
    set_cfg(3'd0, 2'd0, 1'b1, 1'b0);
    @(negedge clk) nxt_pin = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 no step before sync", int'(position), 16);
    @(negedge clk);
    check_pos("R10 R2 step after sync", 17, 672, 741);
    repeat (10) @(negedge clk);
    check("R2 held high no repeat", int'(position), 17);
    nxt_pin = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 falling edge ignored", int'(position), 17);
  endtask

  task automatic t_snap_forward();
    set_cfg(3'd2, 2'd0, 1'b1, 1'b0);
    pulse_nxt();
    check("R7 forward snap 17 to 20", int'(position), 20);
    pulse_nxt();
    check_pos("R4 stride 4", 24, 383, 924);
  endtask

  task automatic t_backward_wrap();
    set_cfg(3'd3, 2'd1, 1'b1, 1'b1);
    pulse_nxt();
    check("R7 R5 backward snap 24 to 16", int'(position), 16);
    pulse_nxt();
    check("R4 R5 stride 16 back", int'(position), 0);
    pulse_nxt();
    check_pos("R5 wrap below zero", 112, 707, -707);
  endtask

  task automatic t_no_trigger();
    set_cfg(3'd7, 2'd0, 1'b1, 1'b0);
    repeat (12) @(negedge clk);
    set_cfg(3'd1, 2'd2, 1'b0, 1'b1);
    repeat (12) @(negedge clk);
    check("R6 config change without trigger", int'(position), 112);
  endtask

  task automatic t_full_steps();
    set_cfg(3'd7, 2'd0, 1'b1, 1'b0);
    pulse_nxt();
    check_pos("R8 two-coil forward wrap", 16, 707, 707);
    set_cfg(3'd5, 2'd0, 1'b1, 1'b0);
    pulse_nxt();
    check_pos("R8 R9 two to one coil forward", 32, 0, 1000);
    set_cfg(3'd5, 2'd0, 1'b0, 1'b0);
    pulse_nxt();
    check_pos("R9 one-coil back to 0", 0, 1000, 0);
    set_cfg(3'd7, 2'd0, 1'b0, 1'b0);
    pulse_nxt();
    check("R8 one to two coil backward", int'(position), 112);
    set_cfg(3'd4, 2'd2, 1'b1, 1'b0);
    pulse_nxt();
    check("R4 mode 6 one-coil", int'(position), 0);
    set_cfg(3'd7, 2'd3, 1'b1, 1'b0);
    pulse_nxt();
    check("R4 mode sum wraps to 2", int'(position), 4);
  endtask

  task automatic t_software_step();
    set_cfg(3'd0, 2'd0, 1'b1, 1'b0);
    @(negedge clk) sw_step_set = 1'b1;
    @(negedge clk) sw_step_set = 1'b0;
    check("R3 pending set", int'(sw_step_pending), 1);
    check("R3 no step yet", int'(position), 4);
    @(negedge clk);
    check("R3 pending cleared", int'(sw_step_pending), 0);
    check("R3 software step", int'(position), 5);
    repeat (6) @(negedge clk);
    check("R3 single software step", int'(position), 5);
  endtask

  task automatic t_coincident();
    @(negedge clk) nxt_pin = 1'b1;
    @(negedge clk) sw_step_set = 1'b1;
    @(negedge clk) sw_step_set = 1'b0;
    @(negedge clk);
    check("R3 coincident step taken", int'(position), 6);
    check("R3 coincident pending cleared", int'(sw_step_pending), 0);
    repeat (8) @(negedge clk);
    check("R3 coincident merged to one step", int'(position), 6);
    nxt_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_half_steps();
    set_cfg(3'd4, 2'd0, 1'b1, 1'b0);
    pulse_nxt();
    check("R7 snap 6 to 16", int'(position), 16);
    pulse_nxt();
    pulse_nxt();
    check_pos("R9 index 48", 48, -707, 707);
    pulse_nxt();
    check_pos("R9 index 64", 64, -1000, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; nxt_pin = 1'b0; dir_pin = 1'b1; step_pins = 2'd0;
    reg_mode = 3'd0; dir_polarity = 1'b0; sw_step_set = 1'b0;
    t_reset();
    t_pin_edge();
    t_snap_forward();
    t_backward_wrap();
    t_no_trigger();
    t_full_steps();
    t_software_step();
    t_coincident();
    t_half_steps();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule